// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Engine

This block is the bus-facing protocol engine of a 16K x 8 serial EEPROM that answers as a target on an I2C bus. It oversamples SCL and SDA with the system clock, finds START and STOP conditions, and checks the device address byte against a fixed family code and three strap inputs. It acknowledges by driving an open-drain SDA low, and it shifts read data out the same way.

On a write it gathers a two-byte word address and then passes each data byte, with its target address, to an external page buffer. A STOP then asks the write engine to commit the page. While that engine reports busy, the device address is not acknowledged, so the host can poll for completion. Reads come from the current-address pointer. The pointer may be set through a dummy write followed by a repeated START, and it advances after every byte sent. The read path fetches bytes through a simple address/data array port.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The target acknowledges a device address byte only when bits 7..4 equal 1010 and bits 3..1 equal the `dev_sel` straps. Bit 0 selects the direction, with 1 for read and 0 for write. Any other address byte gets no acknowledge, and the target ignores the bus until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP that ends a write carrying at least one data byte produces one `wr_commit` pulse. A STOP that ends any other transfer produces none.
- R3: An acknowledge holds SDA low for the whole ninth SCL high period. SDA is released after the acknowledge and after each read byte. The target changes its SDA drive only while SCL is low, and SDA is released after reset.
- R4: A write sends two word-address bytes after the device address: the high byte first, then the low byte. Only the low 6 bits of the high byte are used, and its top two bits are ignored.
- R5: Each written data byte appears on `wb_addr`/`wb_data` with a one-cycle `wb_we` pulse and is acknowledged. Within a transfer the address advances in its low 6 bits only, so it wraps inside its 64-byte page.
- R6: While `wr_busy` is high, the device address byte gets no acknowledge.
- R7: During a read, the target sends another byte after each host acknowledge. A host NACK ends the transfer and leaves SDA released.
- R8: The read pointer advances by one after each byte read and wraps from 16383 to 0.
- R9: A current-address read starts at the address that follows the last byte accessed. After a write, that is the last written address plus one, wrapped within its page.
- R10: A random read loads the pointer with a dummy write of the word address, then uses a repeated START with direction bit 1. The dummy write commits nothing.
- R11: A START in the middle of a transfer aborts it and returns the target to waiting for a device address, with no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Resolved bus data level |
| dev_sel | input | 3 | Strapped device address bits |
| wr_busy | input | 1 | Internal write cycle in progress |
| rd_data | input | 8 | Array byte at `rd_addr`, valid within two clocks of an address change |
| sda_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| rd_addr | output | 14 | Current-address pointer, used as the array read address |
| wb_we | output | 1 | One-cycle strobe for a received data byte |
| wb_addr | output | 14 | Page-buffer address of the received byte |
| wb_data | output | 8 | Received data byte |
| wr_commit | output | 1 | One-cycle request to program the buffered page |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except when it forms a START or STOP. They also assume that each SCL level lasts several system clocks, so that the synchronized edges are separated. The bench's bit tasks hold each SCL phase for at least eight clocks and move SDA only in the middle of the low phase. A monitor flags any SDA change during SCL high that happens outside the START and STOP tasks. Random addresses, lengths and data come from a fixed seed, so the write wrap, read wrap and busy polling paths are all reached in every run.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int AW = 14,
  parameter int PW = 6,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [2:0]    dev_sel,
  input  logic          wr_busy,
  input  logic [7:0]    rd_data,
  output logic          sda_low,
  output logic [AW-1:0] rd_addr,
  output logic          wb_we,
  output logic [AW-1:0] wb_addr,
  output logic [7:0]    wb_data,
  output logic          wr_commit
);
  localparam int HW = AW - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;

  st_t           state;
  logic [2:0]    scl_r, sda_r;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [HW-1:0] ahi;
  logic [AW-1:0] ptr;
  logic          sda_oe, rw, mack, wr_seen;

  wire scl = scl_r[1], scl_d = scl_r[2];
  wire sda = sda_r[1], sda_d = sda_r[2];
  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;

  assign sda_low = sda_oe;
  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= '1; sda_r <= '1;
      state <= S_IDLE; cnt <= '0; sh <= '0; ahi <= '0; ptr <= '0;
      sda_oe <= 1'b0; rw <= 1'b0; mack <= 1'b0; wr_seen <= 1'b0;
      wb_we <= 1'b0; wb_addr <= '0; wb_data <= '0; wr_commit <= 1'b0;
    end else begin
      scl_r <= {scl_r[1:0], scl_in};
      sda_r <= {sda_r[1:0], sda_in};
      wb_we <= 1'b0;
      wr_commit <= 1'b0;
      if (start_c) begin
        state <= S_DEV; cnt <= '0; sda_oe <= 1'b0; wr_seen <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
        wr_commit <= wr_seen; wr_seen <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (cnt == 4'd8) mack <= ~sda;
          else if (state != S_RDAT) sh <= {sh[6:0], sda};
          if (cnt != 4'd9) cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (state)
              S_DEV: begin
                if (sh[7:1] == {DEV_CODE, dev_sel} && !wr_busy) begin
                  sda_oe <= 1'b1; rw <= sh[0];
                end else state <= S_IDLE;
              end
              S_AHI: begin ahi <= sh[HW-1:0]; sda_oe <= 1'b1; end
              S_ALO: begin ptr <= {ahi, sh}; sda_oe <= 1'b1; end
              S_WDAT: begin
                wb_we <= 1'b1; wb_addr <= ptr; wb_data <= sh;
                ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                wr_seen <= 1'b1; sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            sda_oe <= 1'b0;
            case (state)
              S_DEV: state <= rw ? S_RDAT : S_AHI;
              S_AHI: state <= S_ALO;
              S_ALO: state <= S_WDAT;
              S_RDAT: if (!mack) state <= S_IDLE;
              default: state <= state;
            endcase
            if ((state == S_DEV && rw) || (state == S_RDAT && mack)) begin
              sh <= rd_data; sda_oe <= ~rd_data[7]; ptr <= ptr + AW'(1);
            end
          end else if (state == S_RDAT && cnt != 4'd0) begin
            sh <= {sh[6:0], 1'b1};
            sda_oe <= ~sh[6];
          end
        end
      end
    end
  end

  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);
  assert_addr_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && $rose(sda_oe)) |-> sh[7:1] == {DEV_CODE, dev_sel});
  assert_busy_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEV && $rose(sda_oe)) |-> $past(!wr_busy));
  assert_wb_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> state == S_WDAT);
  assert_commit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (state == S_IDLE && !sda_oe));
  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT && $past(state) == S_RDAT && ptr != $past(ptr)) |-> ptr == $past(ptr) + AW'(1));
  assert_start_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_c) |-> (state == S_DEV && !sda_oe && !wr_commit && !wb_we));
endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  logic clk = 0, rst_n = 0, scl_h = 1, sda_h = 1;
  logic [2:0] dev_sel = 3'b101;
  logic [7:0] rd_data = 0;
  logic sda_low, wb_we, wr_commit, wr_busy;
  logic [13:0] rd_addr, wb_addr;
  logic [7:0] wb_data;
  wire sda_line = sda_h & ~sda_low;

  always #5 clk = ~clk;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line), .dev_sel(dev_sel),
    .wr_busy(wr_busy), .rd_data(rd_data), .sda_low(sda_low), .rd_addr(rd_addr),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data), .wr_commit(wr_commit));

  localparam logic [7:0] DW = 8'hAA, DR = 8'hAB;
  int n_chk = 0, n_fail = 0, commits = 0, exp_commits = 0, busy_cnt = 0, glitches = 0;
  bit in_cond = 0, done = 0, prev_scl = 1, prev_sda = 1;
  logic [7:0] mem [int];
  logic [7:0] stage [int];
  logic [7:0] exp_m [int];
  logic [7:0] wdat [64];
  logic [13:0] ptr_exp = 0;

  assign wr_busy = (busy_cnt != 0);

  function automatic logic [7:0] init_val(int a);
    return 8'(a * 37 + (a >> 8) * 11 + 5);
  endfunction
  function automatic logic [7:0] exp_at(int a);
    return exp_m.exists(a) ? exp_m[a] : init_val(a);
  endfunction

  always @(posedge clk) begin
    rd_data <= mem.exists(int'(rd_addr)) ? mem[int'(rd_addr)] : init_val(int'(rd_addr));
    if (wb_we) stage[int'(wb_addr)] = wb_data;
    if (wr_commit) begin
      commits++;
      foreach (stage[k]) mem[k] = stage[k];
      stage.delete();
      busy_cnt = 400;
    end else if (busy_cnt > 0) busy_cnt--;
  end

  always @(negedge clk) begin
    if (rst_n && scl_h && prev_scl && sda_line != prev_sda && !in_cond) glitches++;
    prev_scl = scl_h; prev_sda = sda_line;
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    tick(4); sda_h = 1; tick(4); scl_h = 1; tick(8);
    in_cond = 1; sda_h = 0; tick(8); in_cond = 0; scl_h = 0;
    stage.delete();
  endtask
  task automatic i2c_stop();
    tick(4); sda_h = 0; tick(4); scl_h = 1; tick(8);
    in_cond = 1; sda_h = 1; tick(8); in_cond = 0;
  endtask
  task automatic send_byte(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(4); sda_h = b[i]; tick(4); scl_h = 1; tick(8); scl_h = 0;
    end
    tick(4); sda_h = 1; tick(4); scl_h = 1; tick(4);
    ack = !sda_line; tick(4); scl_h = 0;
  endtask
  task automatic recv_byte(bit host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(4); sda_h = 1; tick(4); scl_h = 1; tick(4); d[i] = sda_line; tick(4); scl_h = 0;
    end
    tick(4); sda_h = !host_ack; tick(4); scl_h = 1; tick(8); scl_h = 0;
  endtask

  task automatic poll(bit expect_first_nack);
    bit ack;
    for (int t = 0; t < 20; t++) begin
      i2c_start(); send_byte(DW, ack); i2c_stop();
      if (t == 0 && expect_first_nack) chk(!ack, "R6 busy nack", ack, 0);
      if (ack) break;
    end
    chk(ack, "R6 poll ack", ack, 1);
  endtask

  task automatic wr(logic [13:0] a, int n, logic [1:0] junk);
    bit ack;
    i2c_start();
    send_byte(DW, ack); chk(ack, "R1 dev ack", ack, 1);
    send_byte({junk, a[13:8]}, ack); chk(ack, "R4 ahi ack", ack, 1);
    send_byte(a[7:0], ack); chk(ack, "R4 alo ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ack); chk(ack, "R5 data ack", ack, 1);
    end
    i2c_stop();
    for (int i = 0; i < n; i++) exp_m[int'({a[13:6], 6'(a[5:0] + 6'(i))})] = wdat[i];
    ptr_exp = {a[13:6], 6'(a[5:0] + 6'(n))};
    exp_commits++;
    tick(6);
    chk(commits == exp_commits, "R2 commit on stop", commits, exp_commits);
    poll(1);
  endtask

  task automatic rd_seq(logic [13:0] a, int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == exp_at(int'(14'(a + 14'(i)))), "R7 R8 read data", d, exp_at(int'(14'(a + 14'(i)))));
    end
    tick(4);
    chk(!sda_low, "R7 released after nack", sda_low, 0);
    i2c_stop();
    ptr_exp = 14'(a + 14'(n));
  endtask

  task automatic rd_rand(logic [13:0] a, int n);
    bit ack;
    i2c_start();
    send_byte(DW, ack); chk(ack, "R10 dummy dev ack", ack, 1);
    send_byte({2'b00, a[13:8]}, ack); chk(ack, "R10 ahi ack", ack, 1);
    send_byte(a[7:0], ack); chk(ack, "R10 alo ack", ack, 1);
    i2c_start();
    send_byte(DR, ack); chk(ack, "R10 read dev ack", ack, 1);
    rd_seq(a, n);
    tick(6);
    chk(commits == exp_commits, "R10 no commit", commits, exp_commits);
  endtask

  task automatic rd_cur(int n);
    bit ack;
    i2c_start();
    send_byte(DR, ack); chk(ack, "R9 dev ack", ack, 1);
    rd_seq(ptr_exp, n);
  endtask

  initial begin
    bit ack;
    int unsigned s;
    s = $urandom(1234);
    tick(5); rst_n = 1; tick(5);
    chk(!sda_low && !wb_we && !wr_commit, "R3 reset state", {sda_low, wb_we, wr_commit}, 0);

    i2c_start(); send_byte(8'hA4, ack); i2c_stop();
    chk(!ack, "R1 wrong strap nack", ack, 0);
    i2c_start(); send_byte(8'hBA, ack); i2c_stop();
    chk(!ack, "R1 wrong code nack", ack, 0);

    wdat[0] = 8'h3C; wdat[1] = 8'hC3;
    wr(14'h3FFE, 2, 2'b11);
    rd_rand(14'h3FFE, 4);

    for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h90 + i);
    wr(14'h12BC, 8, 2'b01);
    rd_cur(3);
    rd_rand(14'h1280, 64);

    i2c_start();
    send_byte(DW, ack); send_byte(8'h01, ack); send_byte(8'h00, ack);
    send_byte(8'hA5, ack); send_byte(8'h5A, ack);
    i2c_start(); i2c_stop();
    tick(6);
    chk(commits == exp_commits, "R11 abort no commit", commits, exp_commits);
    chk(!wr_busy, "R11 no write cycle", wr_busy, 0);
    rd_rand(14'h0100, 2);

    for (int it = 0; it < 20; it++) begin
      logic [13:0] a;
      int n;
      a = 14'($urandom);
      n = 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
      wr(a, n, 2'($urandom));
      if ($urandom % 2 == 0) rd_cur(1 + int'($urandom % 6));
      else rd_rand(a, 1 + int'($urandom % 6));
    end

    chk(glitches == 0, "R3 sda stable while scl high", glitches, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule